// File: doc/BRIEF.md
# Dual-Port Memory with Independent Port Widths

This block is a fully synchronous two-port memory with 16,384 data bits and 2,048 parity bits. Each port has its own clock, enable, write enable, synchronous output reset, address, data and parity inputs, and registered data and parity outputs. A parameter sets each port's width. The port's depth and address width follow from that width, and both ports see the same physical bits.

Per-port parameters set three more things. One chooses what the output register shows during a write: the incoming word, or the word the cell held before. One chooses whether the port acts on the rising or the falling clock edge. One sets the word that the synchronous reset loads into the output register. Typical uses are width conversion between two clock domains, and buffers that are written wide and read narrow.

Top module: `dpr_dual_aspect`

## Requirements
- R1: The width parameter W selects the port shape. W = 1, 2 or 4 gives W data bits, no parity, and 14, 13 or 12 address bits. W = 9, 18 or 36 gives 8, 16 or 32 data bits, 1, 2 or 4 parity bits, and 11, 10 or 9 address bits.
- R2: On an active edge with enable high, write enable low and reset low, the output register loads the word held at the address.
- R3: On an active edge with enable and write enable high and reset low, the data and parity words are stored at the address. Later reads from either port return them.
- R4: A port with the read-first parameter at 0 loads its own incoming data and parity into the output register on the edge that writes them.
- R5: A port with the read-first parameter at 1 loads the cell's previous contents into the output register on the edge that writes new contents.
- R6: While enable is low, the port's output register holds its value and nothing is written, whatever the write enable is.
- R7: On an active edge with enable and reset high, the output register loads the init parameter (data from init bits [DB-1:0], parity from init bits [32+PB-1:32]). Memory is not changed, even with write enable high.
- R8: Data word a of a port with DB data bits occupies linear data bits [a*DB +: DB]. Its parity occupies linear parity bits [a*PB +: PB]. A wide word's low sub-word is therefore the narrow word with the lowest address.
- R9: At widths 1, 2 and 4 the parity output stays 0 and the parity input has no effect.
- R10: The clock-invert parameter set to 1 makes a port act only on falling edges of its clock; at 0 it acts only on rising edges.
- R11: When both ports write the same bit on different edges, the later edge's value is kept. Writes to the same bit on the same instant are not defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_sreset | input | 1 | Port A synchronous output reset |
| a_addr | input | addr_bits(A_WIDTH) | Port A word address |
| a_din | input | data_bits(A_WIDTH) | Port A write data |
| a_pin | input | max(1, par_bits(A_WIDTH)) | Port A write parity |
| a_dout | output | data_bits(A_WIDTH) | Port A registered read data |
| a_pout | output | max(1, par_bits(A_WIDTH)) | Port A registered read parity |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_sreset | input | 1 | Port B synchronous output reset |
| b_addr | input | addr_bits(B_WIDTH) | Port B word address |
| b_din | input | data_bits(B_WIDTH) | Port B write data |
| b_pin | input | max(1, par_bits(B_WIDTH)) | Port B write parity |
| b_dout | output | data_bits(B_WIDTH) | Port B registered read data |
| b_pout | output | max(1, par_bits(B_WIDTH)) | Port B registered read parity |

## Verification
The first instance pairs a 36-wide write-first port on rising edges with a 9-wide read-first port on falling edges. A directed pass writes one wide word and reads its four narrow lanes, which separates a correct lane order and parity placement from a swapped one. A same-cycle write from both ports to one cell shows whether the later edge wins, and a reset combined with a write shows whether memory is left untouched. Randomised mixed traffic over overlapping rows then tells the two output modes apart on every write. The second instance pairs a 4-wide read-first port with an 18-wide write-first port, both on rising edges: it covers concurrent traffic in disjoint rows, cross-port draining, and parity that has no effect on the narrow port.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int ROWS   = 512;
  localparam int ROW_AW = 9;
  localparam int ROW_D  = 32;
  localparam int ROW_P  = 4;
  localparam int ROW_W  = ROW_D + ROW_P;

  function automatic int data_bits(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_bits(input int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int par_port(input int w);
    return (w >= 9) ? w / 9 : 1;
  endfunction

  function automatic int addr_bits(input int w);
    return ROW_AW + $clog2(ROW_D / data_bits(w));
  endfunction
endpackage

// File: rtl/dpr_lane_map.sv
module dpr_lane_map import dpr_pkg::*; #(
  parameter int WIDTH = 36
) (
  input  logic [addr_bits(WIDTH)-1:0] addr,
  input  logic [data_bits(WIDTH)-1:0] din,
  input  logic [par_port(WIDTH)-1:0]  pin,
  input  logic [ROW_W-1:0]            cur,
  output logic [ROW_AW-1:0]           row,
  output logic [ROW_W-1:0]            wmask,
  output logic [ROW_W-1:0]            wvec,
  output logic [data_bits(WIDTH)-1:0] old_d,
  output logic [par_port(WIDTH)-1:0]  old_p
);
  localparam int DB   = data_bits(WIDTH);
  localparam int PB   = par_bits(WIDTH);
  localparam int PBD  = (PB == 0) ? 1 : PB;
  localparam int AW   = addr_bits(WIDTH);
  localparam int SW   = AW - ROW_AW;
  localparam int SUBW = (SW == 0) ? 1 : SW;

  logic [SUBW-1:0] sub;

  assign row = addr[AW-1 -: ROW_AW];

  generate
    if (SW == 0) begin : g_full_row
      assign sub = '0;
    end else begin : g_sub_lane
      assign sub = addr[SW-1:0];
    end
  endgenerate

  // lane select and replicated write word across one storage row
  always_comb begin
    for (int b = 0; b < ROW_D; b++) begin
      wmask[b] = ((b / DB) == int'(sub));
      wvec[b]  = din[b % DB];
    end
    for (int b = 0; b < ROW_P; b++) begin
      wmask[ROW_D+b] = (PB != 0) && ((b / PBD) == int'(sub));
      wvec[ROW_D+b]  = pin[b % PBD];
    end
  end

  assign old_d = cur[int'(sub)*DB +: DB];

  generate
    if (PB == 0) begin : g_no_par
      assign old_p = '0;
    end else begin : g_par
      assign old_p = cur[ROW_D + int'(sub)*PBD +: PBD];
    end
  endgenerate
endmodule

// File: rtl/dpr_port.sv
module dpr_port import dpr_pkg::*; #(
  parameter int         WIDTH      = 36,
  parameter bit         READ_FIRST = 1'b0,
  parameter bit         CLK_INV    = 1'b0,
  parameter logic [35:0] INIT      = '0,
  parameter bit         IS_B       = 1'b0
) (
  input  logic                        clk,
  input  logic                        en,
  input  logic                        we,
  input  logic                        sreset,
  input  logic [addr_bits(WIDTH)-1:0] addr,
  input  logic [data_bits(WIDTH)-1:0] din,
  input  logic [par_port(WIDTH)-1:0]  pin,
  output logic [data_bits(WIDTH)-1:0] dout,
  output logic [par_port(WIDTH)-1:0]  pout,
  output logic [ROW_AW-1:0]           row,
  input  logic [ROW_AW-1:0]           look_row,
  output logic [ROW_W-1:0]            look_mem,
  output logic [ROW_W-1:0]            look_stamp,
  input  logic [ROW_W-1:0]            peer_mem,
  input  logic [ROW_W-1:0]            peer_stamp
);
  localparam int DB  = data_bits(WIDTH);
  localparam int PB  = par_bits(WIDTH);
  localparam int PPW = par_port(WIDTH);
  localparam logic [DB-1:0]  INIT_D = INIT[DB-1:0];
  localparam logic [PPW-1:0] INIT_P = (PB > 0) ? INIT[ROW_D +: PPW] : '0;

  logic eclk;
  assign eclk = clk ^ CLK_INV;

  // each port owns one bank and one stamp array; a bit is current in this
  // bank when its stamp relation to the peer stamp marks this port as last writer
  logic [ROW_W-1:0] mem   [ROWS];
  logic [ROW_W-1:0] stamp [ROWS];

  logic [ROW_W-1:0] cur, wmask, wvec;
  logic [DB-1:0]    old_d;
  logic [PPW-1:0]   old_p;

  dpr_lane_map #(.WIDTH(WIDTH)) u_map (
    .addr(addr), .din(din), .pin(pin), .cur(cur),
    .row(row), .wmask(wmask), .wvec(wvec), .old_d(old_d), .old_p(old_p)
  );

  always_comb begin
    for (int b = 0; b < ROW_W; b++)
      cur[b] = ((stamp[row][b] ^ peer_stamp[b]) == IS_B) ? mem[row][b] : peer_mem[b];
  end

  assign look_mem   = mem[look_row];
  assign look_stamp = stamp[look_row];

  always_ff @(posedge eclk) begin
    if (en && we && !sreset) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (wmask[b]) begin
          mem[row][b]   <= wvec[b];
          stamp[row][b] <= peer_stamp[b] ^ IS_B;
        end
      end
    end
  end

  always_ff @(posedge eclk) begin
    if (en) begin
      if (sreset) begin
        dout <= INIT_D;
        pout <= INIT_P;
      end else if (we && !READ_FIRST) begin
        dout <= din;
        pout <= (PB > 0) ? pin : '0;
      end else begin
        dout <= old_d;
        pout <= old_p;
      end
    end
  end

  logic armed = 1'b0;
  always_ff @(posedge eclk) armed <= 1'b1;

  assert_idle_hold_R6: assert property (@(posedge eclk) disable iff (!armed)
    !en |=> ($stable(dout) && $stable(pout)));

  assert_sreset_init_R7: assert property (@(posedge eclk) disable iff (!armed)
    (en && sreset) |=> (dout == INIT_D && pout == INIT_P));

  generate
    if (READ_FIRST) begin : g_chk_rf
      assert_read_first_R5: assert property (@(posedge eclk) disable iff (!armed)
        (en && we && !sreset) |=> (dout == $past(old_d) && pout == $past(old_p)));
    end else begin : g_chk_wf
      assert_write_first_R4: assert property (@(posedge eclk) disable iff (!armed)
        (en && we && !sreset) |=> (dout == $past(din)));
    end
    if (PB == 0) begin : g_chk_nopar
      always_comb assert_no_parity_R9: assert (pout == '0 || !armed);
    end
  endgenerate
endmodule

// File: rtl/dpr_dual_aspect.sv
module dpr_dual_aspect import dpr_pkg::*; #(
  parameter int          A_WIDTH      = 36,
  parameter int          B_WIDTH      = 36,
  parameter bit          A_READ_FIRST = 1'b0,
  parameter bit          B_READ_FIRST = 1'b0,
  parameter bit          A_CLK_INV    = 1'b0,
  parameter bit          B_CLK_INV    = 1'b0,
  parameter logic [35:0] A_INIT       = '0,
  parameter logic [35:0] B_INIT       = '0
) (
  input  logic                          a_clk,
  input  logic                          a_en,
  input  logic                          a_we,
  input  logic                          a_sreset,
  input  logic [addr_bits(A_WIDTH)-1:0] a_addr,
  input  logic [data_bits(A_WIDTH)-1:0] a_din,
  input  logic [par_port(A_WIDTH)-1:0]  a_pin,
  output logic [data_bits(A_WIDTH)-1:0] a_dout,
  output logic [par_port(A_WIDTH)-1:0]  a_pout,
  input  logic                          b_clk,
  input  logic                          b_en,
  input  logic                          b_we,
  input  logic                          b_sreset,
  input  logic [addr_bits(B_WIDTH)-1:0] b_addr,
  input  logic [data_bits(B_WIDTH)-1:0] b_din,
  input  logic [par_port(B_WIDTH)-1:0]  b_pin,
  output logic [data_bits(B_WIDTH)-1:0] b_dout,
  output logic [par_port(B_WIDTH)-1:0]  b_pout
);
  logic [ROW_AW-1:0] row_a, row_b;
  logic [ROW_W-1:0]  mem_to_a, stamp_to_a, mem_to_b, stamp_to_b;

  dpr_port #(
    .WIDTH(A_WIDTH), .READ_FIRST(A_READ_FIRST), .CLK_INV(A_CLK_INV),
    .INIT(A_INIT), .IS_B(1'b0)
  ) u_port_a (
    .clk(a_clk), .en(a_en), .we(a_we), .sreset(a_sreset), .addr(a_addr),
    .din(a_din), .pin(a_pin), .dout(a_dout), .pout(a_pout),
    .row(row_a), .look_row(row_b), .look_mem(mem_to_b), .look_stamp(stamp_to_b),
    .peer_mem(mem_to_a), .peer_stamp(stamp_to_a)
  );

  dpr_port #(
    .WIDTH(B_WIDTH), .READ_FIRST(B_READ_FIRST), .CLK_INV(B_CLK_INV),
    .INIT(B_INIT), .IS_B(1'b1)
  ) u_port_b (
    .clk(b_clk), .en(b_en), .we(b_we), .sreset(b_sreset), .addr(b_addr),
    .din(b_din), .pin(b_pin), .dout(b_dout), .pout(b_pout),
    .row(row_b), .look_row(row_a), .look_mem(mem_to_a), .look_stamp(stamp_to_a),
    .peer_mem(mem_to_b), .peer_stamp(stamp_to_b)
  );
endmodule

// File: tb/dpr_dual_aspect_test.sv
`timescale 1ns/1ps
module dpr_dual_aspect_test;
  localparam logic [35:0] AI = 36'h5_A5A5_0F0F;
  localparam logic [35:0] BI = 36'h1_0000_00C3;
  localparam logic [35:0] CI = 36'h0_0000_0009;
  localparam logic [35:0] DI = 36'h3_0000_BEEF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  // instance one: A 36 write-first rising, B 9 read-first falling
  logic a_en = 0, a_we = 0, a_sr = 0; logic [8:0] a_addr = '0;
  logic [31:0] a_din = '0; logic [3:0] a_pin = '0; logic [31:0] a_dout; logic [3:0] a_pout;
  logic b_en = 0, b_we = 0, b_sr = 0; logic [10:0] b_addr = '0;
  logic [7:0] b_din = '0; logic [0:0] b_pin = '0; logic [7:0] b_dout; logic [0:0] b_pout;
  // instance two: C 4 read-first rising, D 18 write-first rising
  logic c_en = 0, c_we = 0, c_sr = 0; logic [11:0] c_addr = '0;
  logic [3:0] c_din = '0; logic [0:0] c_pin = '0; logic [3:0] c_dout; logic [0:0] c_pout;
  logic d_en = 0, d_we = 0, d_sr = 0; logic [9:0] d_addr = '0;
  logic [15:0] d_din = '0; logic [1:0] d_pin = '0; logic [15:0] d_dout; logic [1:0] d_pout;

  dpr_dual_aspect #(.A_WIDTH(36), .B_WIDTH(9), .A_READ_FIRST(0), .B_READ_FIRST(1),
    .A_CLK_INV(0), .B_CLK_INV(1), .A_INIT(AI), .B_INIT(BI)) uut (
    .a_clk(clk), .a_en(a_en), .a_we(a_we), .a_sreset(a_sr), .a_addr(a_addr),
    .a_din(a_din), .a_pin(a_pin), .a_dout(a_dout), .a_pout(a_pout),
    .b_clk(clk), .b_en(b_en), .b_we(b_we), .b_sreset(b_sr), .b_addr(b_addr),
    .b_din(b_din), .b_pin(b_pin), .b_dout(b_dout), .b_pout(b_pout));

  dpr_dual_aspect #(.A_WIDTH(4), .B_WIDTH(18), .A_READ_FIRST(1), .B_READ_FIRST(0),
    .A_CLK_INV(0), .B_CLK_INV(0), .A_INIT(CI), .B_INIT(DI)) uut2 (
    .a_clk(clk), .a_en(c_en), .a_we(c_we), .a_sreset(c_sr), .a_addr(c_addr),
    .a_din(c_din), .a_pin(c_pin), .a_dout(c_dout), .a_pout(c_pout),
    .b_clk(clk), .b_en(d_en), .b_we(d_we), .b_sreset(d_sr), .b_addr(d_addr),
    .b_din(d_din), .b_pin(d_pin), .b_dout(d_dout), .b_pout(d_pout));

  int n_checks = 0, n_err = 0;
  bit done = 0, started = 0;
  logic [16383:0] md [2];
  logic [2047:0]  mp [2];
  logic [35:0] ea, eb, ec, ed;

  function automatic logic [35:0] pk(input logic [31:0] d, input logic [3:0] p);
    return {p, d};
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // behavioural port model over linear bit spaces
  task automatic mop(input int m, input int w, input bit rf, input bit en, input bit we,
                     input bit sr, input int addr, input logic [31:0] din, input logic [3:0] pin,
                     input logic [35:0] init, inout logic [35:0] q, output string tag);
    int db, pb; logic [35:0] old;
    db = (w >= 9) ? (w / 9) * 8 : w;
    pb = (w >= 9) ? w / 9 : 0;
    tag = "R2";
    if (!en) begin tag = "R6"; return; end
    if (sr) begin
      q = '0;
      for (int i = 0; i < db; i++) q[i] = init[i];
      for (int i = 0; i < pb; i++) q[32+i] = init[32+i];
      tag = "R7";
      return;
    end
    old = '0;
    for (int i = 0; i < db; i++) old[i] = md[m][addr*db+i];
    for (int i = 0; i < pb; i++) old[32+i] = mp[m][addr*pb+i];
    if (we) begin
      for (int i = 0; i < db; i++) md[m][addr*db+i] = din[i];
      for (int i = 0; i < pb; i++) mp[m][addr*pb+i] = pin[i];
      if (rf) begin q = old; tag = "R5"; end
      else begin
        q = '0;
        for (int i = 0; i < db; i++) q[i] = din[i];
        for (int i = 0; i < pb; i++) q[32+i] = pin[i];
        tag = "R4";
      end
    end else q = old;
  endtask

  task automatic step();
    string ta, tb, tc, td;
    logic [35:0] prev_b;
    prev_b = eb;
    mop(0, 36, 0, a_en, a_we, a_sr, int'(a_addr), a_din, a_pin, AI, ea, ta);
    mop(0, 9, 1, b_en, b_we, b_sr, int'(b_addr), 32'(b_din), 4'(b_pin), BI, eb, tb);
    mop(1, 4, 1, c_en, c_we, c_sr, int'(c_addr), 32'(c_din), 4'(c_pin), CI, ec, tc);
    mop(1, 18, 0, d_en, d_we, d_sr, int'(d_addr), 32'(d_din), 4'(d_pin), DI, ed, td);
    @(posedge clk); #1;
    chk(ta, pk(a_dout, a_pout), ea, "uut port A");
    if (started) chk("R10", pk(32'(b_dout), 4'(b_pout)), prev_b, "uut port B before its falling edge");
    chk(tc, pk(32'(c_dout), 4'(c_pout)), ec, "uut2 port A");
    chk("R9", 36'(c_pout), 36'd0, "uut2 narrow port parity");
    chk(td, pk(32'(d_dout), 4'(d_pout)), ed, "uut2 port B");
    @(negedge clk); #1;
    chk(tb, pk(32'(b_dout), 4'(b_pout)), eb, "uut port B");
    started = 1;
  endtask

  task automatic idle1();
    a_en = 0; a_we = 0; a_sr = 0; b_en = 0; b_we = 0; b_sr = 0;
  endtask

  // second instance stimulus, indexed by step number
  task automatic set_u2(input int n);
    c_en = 0; c_we = 0; c_sr = 0; d_en = 0; d_we = 0; d_sr = 0;
    c_pin = 1'($urandom);
    if (n == 0) begin
      c_en = 1; c_sr = 1; c_we = 1; d_en = 1; d_sr = 1; d_we = 1;
    end else if (n <= 32) begin
      d_en = 1; d_we = 1; d_addr = 10'(n - 1); d_din = 16'($urandom); d_pin = 2'($urandom);
    end else if (n <= 232) begin
      c_en = ($urandom % 4) != 0; c_we = 1'($urandom); c_sr = ($urandom % 16) == 0;
      c_addr = 12'($urandom % 64); c_din = 4'($urandom);
      d_en = ($urandom % 4) != 0; d_we = 1'($urandom); d_sr = ($urandom % 16) == 0;
      d_addr = 10'(16 + $urandom % 16); d_din = 16'($urandom); d_pin = 2'($urandom);
    end else if (n <= 248) begin
      d_en = 1; d_addr = 10'(n - 233);
    end else if (n <= 312) begin
      c_en = 1; c_addr = 12'(n - 249);
    end
  endtask

  int sn = 0;
  task automatic go();
    set_u2(sn);
    step();
    sn++;
  endtask

  initial begin
    md[0] = '0; md[1] = '0; mp[0] = '0; mp[1] = '0;
    ea = '0; eb = '0; ec = '0; ed = '0;
    // R1 port shapes
    chk("R1", 36'($bits(a_addr) * 100 + $bits(a_dout) * 10 + $bits(a_pout)), 36'(9*100 + 320 + 4), "width36 shape");
    chk("R1", 36'($bits(b_addr) * 100 + $bits(b_dout) * 10 + $bits(b_pout)), 36'(11*100 + 80 + 1), "width9 shape");
    chk("R1", 36'($bits(c_addr) * 100 + $bits(c_dout)), 36'(12*100 + 4), "width4 shape");
    chk("R1", 36'($bits(d_addr) * 100 + $bits(d_dout) * 10 + $bits(d_pout)), 36'(10*100 + 160 + 2), "width18 shape");
    // reset state through synchronous reset (R7), write enable must not store
    a_en = 1; a_sr = 1; a_we = 1; b_en = 1; b_sr = 1; b_we = 1;
    go();
    // fill sixteen wide rows, B idle (R6)
    for (int i = 0; i < 16; i++) begin
      idle1(); a_en = 1; a_we = 1; a_addr = 9'(i);
      a_din = $urandom; a_pin = 4'($urandom); b_we = 1'($urandom);
      go();
    end
    // R8 lane order
    idle1(); a_en = 1; a_we = 1; a_addr = 9'd3; a_din = 32'h8877_6655; a_pin = 4'b1010;
    go();
    for (int k = 0; k < 4; k++) begin
      idle1(); b_en = 1; b_addr = 11'(12 + k);
      go();
      chk("R8", pk(32'(b_dout), 4'(b_pout)),
          pk(32'((32'h8877_6655 >> (8*k)) & 32'hFF), 4'((4'b1010 >> k) & 4'b1)), "narrow lane of wide word");
    end
    // R11 same cycle, B edge falls later
    idle1(); a_en = 1; a_we = 1; a_addr = 9'd5; a_din = 32'h1234_5678; a_pin = 4'hF;
    b_en = 1; b_we = 1; b_addr = 11'd20; b_din = 8'h3C; b_pin = 1'b0;
    go();
    idle1(); a_en = 1; a_addr = 9'd5;
    go();
    chk("R11", pk(a_dout, a_pout), pk(32'h1234_563C, 4'hE), "later edge keeps cell");
    // R3 B reads a lane that A wrote
    idle1(); b_en = 1; b_addr = 11'd21;
    go();
    chk("R3", pk(32'(b_dout), 4'(b_pout)), pk(32'h56, 4'h1), "cross-port read");
    // R7 reset with write enable leaves memory unchanged
    idle1(); b_en = 1; b_sr = 1; b_we = 1; b_addr = 11'd21; b_din = 8'hFF; b_pin = 1'b0;
    go();
    chk("R7", pk(32'(b_dout), 4'(b_pout)), pk(32'hC3, 4'h1), "init load");
    idle1(); b_en = 1; b_addr = 11'd21;
    go();
    chk("R7", pk(32'(b_dout), 4'(b_pout)), pk(32'h56, 4'h1), "memory untouched by reset");
    // mixed traffic over overlapping rows
    for (int i = 0; i < 300; i++) begin
      a_en = ($urandom % 4) != 0; a_we = 1'($urandom); a_sr = ($urandom % 16) == 0;
      a_addr = 9'($urandom % 16); a_din = $urandom; a_pin = 4'($urandom);
      b_en = ($urandom % 4) != 0; b_we = 1'($urandom); b_sr = ($urandom % 16) == 0;
      b_addr = 11'($urandom % 64); b_din = 8'($urandom); b_pin = 1'($urandom);
      go();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule